// File: doc/BRIEF.md
# Dual-Input Tamper Detector with Backup Erase

This block watches two asynchronous tamper pins from a slow clock domain. Each pin is synchronized, optionally filtered by a debounce counter, and compared against a programmable active level. When an enabled input sees a qualified event, a sticky per-input flag is set. An interrupt output follows those flags when interrupts are enabled.

The block also holds a bank of 24 backup words of 32 bits each, written and read by software through the same register port. A new tamper event can make hardware wipe the whole bank, one word per cycle. A ready bit tells software when writes to the bank or its control word have settled and no wipe is running. Software reaches every register through a word-addressed write strobe and a combinational read port.

Word address map: 0 is control, 1 is status, 2 is backup control, and 8 to 31 are backup words 0 to 23.

Top module: `tamper_guard`

## Requirements
- R1: After reset the control word and status word read 0, the backup control word reads 2 (bit 1 ready = 1, bit 0 access = 0), and irq is 0.
- R2: Each pin passes a two-flop synchronizer. Without debounce, an active level present before one rising edge sets its status flag at the third rising edge, so a one-cycle pulse is caught.
- R3: Control bits 6 and 7 pick the active level of input 0 and input 1 (1 = high, 0 = low). A pin held at the other level never sets its flag.
- R4: Control bits 2 and 3 enable detection on input 0 and input 1. A disabled input never sets its flag.
- R5: Control bits 4 and 5 enable debounce on input 0 and input 1. With debounce, an event needs 4 consecutive active synchronized samples, so a 3-cycle pulse is ignored and a 4-cycle pulse is caught.
- R6: Status bits 0 and 1 are sticky flags for input 0 and input 1. Writing 1 to a bit clears it and writing 0 has no effect. If a qualified event and a clear arrive in the same cycle, the event wins.
- R7: irq equals control bit 0 ANDed with the OR of the status flags.
- R8: Backup control bit 0 gates the bank. While it is 0, backup reads return 0 and backup writes are discarded. The stored contents are kept.
- R9: When control bit 1 is set and a flag goes from 0 to 1, hardware clears backup words 0 to 23 in order, one per cycle. While the wipe runs, backup reads return 0 and backup writes are discarded.
- R10: The ready bit (backup control bit 1) is 0 for 3 cycles after a write to backup control or an accepted backup write, and for the whole wipe. Software cannot write it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tampPin | input | 2 | Asynchronous tamper inputs |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 6 | Word address for the read and write port |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| irq | output | 1 | Tamper interrupt |

## Verification
The properties assume that regWr is a clean synchronous strobe and that the tamper pins are the only asynchronous inputs. Those pins can change at any time. The bench therefore changes every input on the falling edge and samples reads half a cycle after each rising edge. Before it retargets an input to a new active level, it disables detection and parks the pins at their idle level. This keeps stale synchronizer contents from causing a new event that no check expects.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int DATA_W     = 32;
  localparam int BANK_DEPTH = 24;
  localparam int IDX_W      = $clog2(BANK_DEPTH);
  localparam int ADDR_W     = 6;
  localparam int NUM_IN     = 2;
  localparam int CTRL_W     = 2 + 3 * NUM_IN;

  // control bit positions
  localparam int BIT_IRQEN  = 0;
  localparam int BIT_WIPEEN = 1;
  localparam int BIT_DETEN  = 2;
  localparam int BIT_DBEN   = 2 + NUM_IN;
  localparam int BIT_LEVEL  = 2 + 2 * NUM_IN;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_BKCTL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_BANK0 = ADDR_W'(8);

  typedef struct packed {
    logic              wrStb;
    logic [IDX_W-1:0]  wrIdx;
    logic [DATA_W-1:0] wrData;
    logic              clrStb;
    logic [IDX_W-1:0]  clrIdx;
  } bank_cmd_t;
endpackage

// File: rtl/tamper_detect.sv
module tamper_detect #(
  parameter int DB_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinAsync,
  input  logic activeLevel,
  input  logic dbEn,
  output logic qualified
);
  localparam int CW = $clog2(DB_LEN) + 1;
  localparam logic [CW-1:0] RUN_MAX = CW'(DB_LEN - 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;
  logic          active;

  assign active = (syncQ[1] == activeLevel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      runCnt <= '0;
    end else begin
      syncQ <= {syncQ[0], pinAsync};
      if (!active)              runCnt <= '0;
      else if (runCnt < RUN_MAX) runCnt <= runCnt + 1'b1;
    end
  end

  assign qualified = active && (!dbEn || runCnt == RUN_MAX);
endmodule

// File: rtl/tamper_ctrl.sv
module tamper_ctrl
  import tamper_pkg::*;
#(
  parameter int DB_LEN     = 4,
  parameter int SETTLE_CYC = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  tampPin,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [DATA_W-1:0]  bankRdData,
  output bank_cmd_t          bankCmd,
  output logic [IDX_W-1:0]   bankRdIdx,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irq
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_DEPTH - 1);
  localparam logic [ADDR_W-1:0] ADDR_BANK_END = ADDR_W'(int'(ADDR_BANK0) + BANK_DEPTH);

  logic [CTRL_W-1:0] ctrlReg;
  logic [NUM_IN-1:0] status, qual, hitEn, clrMask;
  logic              accessEn, eraseBusy, bankOk, newEvent, ready;
  logic [IDX_W-1:0]  eraseIdx, bankIdx;
  logic [SW-1:0]     settleCnt;
  logic              isCtrl, isStat, isBkCtl, isBank;

  assign isCtrl  = (regAddr == ADDR_CTRL);
  assign isStat  = (regAddr == ADDR_STAT);
  assign isBkCtl = (regAddr == ADDR_BKCTL);
  assign isBank  = (regAddr >= ADDR_BANK0) && (regAddr < ADDR_BANK_END);
  assign bankIdx = IDX_W'(regAddr - ADDR_BANK0);

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    tamper_detect #(.DB_LEN(DB_LEN)) detect_i (
      .clk        (clk),
      .rstN       (rstN),
      .pinAsync   (tampPin[g]),
      .activeLevel(ctrlReg[BIT_LEVEL + g]),
      .dbEn       (ctrlReg[BIT_DBEN + g]),
      .qualified  (qual[g])
    );
    assign hitEn[g] = qual[g] & ctrlReg[BIT_DETEN + g];
  end

  assign clrMask  = (regWr && isStat) ? regWdata[NUM_IN-1:0] : '0;
  assign newEvent = |(hitEn & ~status);
  assign bankOk   = accessEn & ~eraseBusy;
  assign ready    = (settleCnt == '0) && !eraseBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      status    <= '0;
      accessEn  <= 1'b0;
      eraseBusy <= 1'b0;
      eraseIdx  <= '0;
      settleCnt <= '0;
    end else begin
      if (regWr && isCtrl)  ctrlReg  <= regWdata[CTRL_W-1:0];
      if (regWr && isBkCtl) accessEn <= regWdata[0];
      status <= (status & ~clrMask) | hitEn;

      if (newEvent && ctrlReg[BIT_WIPEEN] && !eraseBusy) begin
        eraseBusy <= 1'b1;
        eraseIdx  <= '0;
      end else if (eraseBusy) begin
        if (eraseIdx == LAST_IDX) eraseBusy <= 1'b0;
        eraseIdx <= eraseIdx + 1'b1;
      end

      if (regWr && (isBkCtl || (isBank && bankOk))) settleCnt <= SW'(SETTLE_CYC);
      else if (settleCnt != '0)                     settleCnt <= settleCnt - 1'b1;
    end
  end

  always_comb begin
    bankCmd.wrStb  = regWr && isBank && bankOk;
    bankCmd.wrIdx  = bankIdx;
    bankCmd.wrData = regWdata;
    bankCmd.clrStb = eraseBusy;
    bankCmd.clrIdx = eraseIdx;
  end

  assign bankRdIdx = bankIdx;

  always_comb begin
    regRdata = '0;
    if (isCtrl)      regRdata = DATA_W'(ctrlReg);
    else if (isStat) regRdata = DATA_W'(status);
    else if (isBkCtl) regRdata = DATA_W'({ready, accessEn});
    else if (isBank && bankOk) regRdata = bankRdData;
  end

  assign irq = ctrlReg[BIT_IRQEN] & (|status);
endmodule

// File: rtl/tamper_bank.sv
module tamper_bank
  import tamper_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bank_cmd_t         bankCmd,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [BANK_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BANK_DEPTH; i++) mem[i] <= '0;
    end else if (bankCmd.clrStb) begin
      mem[bankCmd.clrIdx] <= '0;
    end else if (bankCmd.wrStb) begin
      mem[bankCmd.wrIdx] <= bankCmd.wrData;
    end
  end

  assign rdData = (int'(rdIdx) < BANK_DEPTH) ? mem[rdIdx] : '0;
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamper_pkg::*;
#(
  parameter int DB_LEN     = 4,
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        tampPin,
  input  logic              regWr,
  input  logic [5:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);
  bank_cmd_t         bankCmd;
  logic [IDX_W-1:0]  bankRdIdx;
  logic [DATA_W-1:0] bankRdData;

  tamper_ctrl #(.DB_LEN(DB_LEN), .SETTLE_CYC(SETTLE_CYC)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tampPin   (tampPin),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .bankRdData(bankRdData),
    .bankCmd   (bankCmd),
    .bankRdIdx (bankRdIdx),
    .regRdata  (regRdata),
    .irq       (irq)
  );

  tamper_bank bank_i (
    .clk    (clk),
    .rstN   (rstN),
    .bankCmd(bankCmd),
    .rdIdx  (bankRdIdx),
    .rdData (bankRdData)
  );
endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk
  import tamper_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      regWr,
  input logic      irq,
  input bank_cmd_t bankCmd
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_DEPTH - 1);

  // R9
  wipe_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankCmd.clrStb && bankCmd.clrIdx != LAST_IDX) |=>
      (bankCmd.clrStb && bankCmd.clrIdx == $past(bankCmd.clrIdx) + 1'b1));

  // R9
  wipe_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bankCmd.clrStb) |-> (bankCmd.clrIdx == '0));

  // R9
  no_write_in_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bankCmd.clrStb && bankCmd.wrStb));

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !regWr) |=> irq);

  // R8
  write_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankCmd.wrStb |-> regWr);
endmodule

bind tamper_guard tamper_guard_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .regWr  (regWr),
  .irq    (irq),
  .bankCmd(bankCmd)
);

// File: tb/tamper_guard_tb.sv
module tamper_guard_tb_top;
  localparam int CLK_P  = 10;
  localparam int NVEC   = 10;
  localparam logic [5:0] A_CTRL = 6'd0, A_STAT = 6'd1, A_BK = 6'd2, A_B0 = 6'd8;

  // vector: {ctrl, activePins, holdCycles, expectedStatus}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h04, 2'b10, 4'd1, 2'b01},   // R2 one-cycle pulse, low level
    {8'h88, 2'b11, 4'd1, 2'b10},   // R3 input 1 high level
    {8'h0D, 2'b00, 4'd1, 2'b11},   // R7 both, irq enabled
    {8'h00, 2'b00, 4'd5, 2'b00},   // R4 disabled
    {8'h14, 2'b10, 4'd3, 2'b00},   // R5 short glitch filtered
    {8'h14, 2'b10, 4'd4, 2'b01},   // R5 four samples pass
    {8'hC4, 2'b01, 4'd2, 2'b01},   // R3 high level input 0
    {8'h04, 2'b11, 4'd4, 2'b00},   // R3 pin stays at wrong level
    {8'h2C, 2'b00, 4'd2, 2'b01},   // R5 debounce only on input 1
    {8'h08, 2'b00, 4'd3, 2'b10}    // R4 input 0 not enabled
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  tampPin = 2'b11;
  logic        regWr = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_P/2) clk = ~clk;

  tamper_guard dut_i (
    .clk(clk), .rstN(rstN), .tampPin(tampPin), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    tick(2);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); check("R1 status", d, 32'h0);
    rd(A_BK, d);   check("R1 backup ctl", d, 32'h2);
    check("R1 irq", {31'b0, irq}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c;
      logic [1:0] act, idle, ex;
      int hold;
      c = VEC[v][15:8]; act = VEC[v][7:6]; hold = int'(VEC[v][5:2]); ex = VEC[v][1:0];
      idle = ~{c[7], c[6]};
      wr(A_CTRL, 32'h0);
      tampPin = idle;
      tick(4);
      wr(A_STAT, 32'h3);
      wr(A_CTRL, {24'b0, c});
      tampPin = act;
      tick(hold);
      tampPin = idle;
      tick(6);
      rd(A_STAT, d);
      check($sformatf("R2-vec%0d status", v), d, {30'b0, ex});
      check($sformatf("R7 vec%0d irq", v), {31'b0, irq}, {31'b0, c[0] & (|ex)});
    end

    // R8 access gate
    wr(A_CTRL, 32'h0);
    tampPin = 2'b11;
    tick(4);
    wr(A_STAT, 32'h3);
    wr(A_B0 + 6'd3, 32'hDEADBEEF);
    rd(A_B0 + 6'd3, d); check("R8 read while gated", d, 32'h0);
    wr(A_BK, 32'h1);
    // R10 settle window after backup control write
    rd(A_BK, d); check("R10 not ready after write", d, 32'h1);
    tick(2);
    rd(A_BK, d); check("R10 still settling", d, 32'h1);
    tick(1);
    rd(A_BK, d); check("R10 ready after settle", d, 32'h3);
    rd(A_B0 + 6'd3, d); check("R8 gated write discarded", d, 32'h0);
    wr(A_B0 + 6'd3, 32'h12345678);
    rd(A_BK, d); check("R10 busy after bank write", d, 32'h1);
    tick(3);
    rd(A_B0 + 6'd3, d); check("R8 readback", d, 32'h12345678);
    wr(A_BK, 32'h0);
    rd(A_B0 + 6'd3, d); check("R8 read gated again", d, 32'h0);
    wr(A_BK, 32'h3); // R10 ready bit written as 1 must not stick
    rd(A_BK, d); check("R10 ready not writable", d, 32'h1);
    tick(3);
    rd(A_B0 + 6'd3, d); check("R8 contents kept", d, 32'h12345678);

    // R9 wipe
    for (int i = 0; i < 24; i++) wr(A_B0 + 6'(i), 32'h01010101 * (i + 1));
    tick(3);
    rd(A_B0 + 6'd23, d); check("R8 last word", d, 32'h18181818);
    wr(A_CTRL, 32'h07);
    tampPin = 2'b10;
    tick(3);
    rd(A_STAT, d); check("R6 flag set", d, 32'h1);
    rd(A_B0 + 6'd1, d); check("R9 read zero during wipe", d, 32'h0);
    wr(A_B0 + 6'd5, 32'hAAAA5555);
    tick(15);
    rd(A_BK, d); check("R10 not ready during wipe", d, 32'h1);
    check("R7 irq during wipe", {31'b0, irq}, 32'h1);
    tick(10);
    rd(A_BK, d); check("R10 ready after wipe", d, 32'h3);
    for (int i = 0; i < 24; i++) begin
      rd(A_B0 + 6'(i), d);
      check($sformatf("R9 word %0d wiped", i), d, 32'h0);
    end

    // R6 set wins over clear while input still active
    wr(A_CTRL, 32'h05);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); check("R6 set wins over clear", d, 32'h1);
    tampPin = 2'b11;
    tick(4);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R6 write 0 no effect", d, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); check("R6 write 1 clears", d, 32'h0);
    check("R7 irq low after clear", {31'b0, irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule